// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces square waves whose interval and duty are both set by software. It has two 8-bit down-counting channels that run independently. Each channel has its own pair of reload values. One value sets how long the output stays low, and the other sets how long it stays high. A control bit joins the two channels into a single 16-bit generator for longer or finer-grained periods. A shared prescaler divides the machine clock to form the count tick.

Software programs the block through a plain write strobe with an address and a data byte. Each channel has a run input, and each output pin has its own enable input. Each channel owns two pins: one carries the pulse and the other its complement. A period-end flag per channel stays set until software clears it.

Top module: `ppg_timer`

## Requirements
- R1: After reset every pulse pin is low and both period flags are clear.
- R2: A running channel holds its true pin low for (L+1) ticks, then high for (H+1) ticks, and repeats. L is the low reload (address 0 for channel 0, address 2 for channel 1) and H is the high reload (address 1 for channel 0, address 3 for channel 1).
- R3: The tick divisor comes from bits [3:1] of the control byte (address 4). Values 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 clocks per tick, and values 5 to 7 give 16.
- R4: With chaining off, channel 1 (true pin 2, complement pin 3) runs from its own reloads and run input, independent of channel 0 (pins 0 and 1).
- R5: When bit 0 of the control byte is set, a single 16-bit generator runs from run input 0. Its low reload is {channel 1 low, channel 0 low} and its high reload is {channel 1 high, channel 0 high}. Every pin pair follows this generator.
- R6: A reload written while a period is in progress does not alter that period; the new value applies from the next period start.
- R7: A pin whose output enable is 0 stays low whatever its channel does.
- R8: While a channel runs, its complement pin (pin 2k+1) is the inverse of its true pin (pin 2k), provided both pins are enabled.
- R9: Each period end sets that channel's flag; in chained mode this is flag 0. Writing address 5 with data bit k equal to 0 clears flag k. Writing a 1 in that bit leaves flag k unchanged.
- R10: One clock after the run input drops, the channel's pins go low and its counter stops. A later restart begins with a complete low phase of (L+1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| run_en | input | 2 | Run input per channel |
| out_en | input | 4 | Per-pin output enable |
| pulse_out | output | 4 | Pulse pins: 2k true, 2k+1 complement of channel k |
| irq | output | 2 | Period-end flag per channel |

## Verification
Reload pairs are chosen so that the low and high widths differ; an exchange of the two phases would then show up at once. The measured widths are compared against (L+1) and (H+1) times the divisor for several prescaler codes, including a code above the last legal step. Channel 1 runs with values unlike channel 0's at the same time, which separates the channels. Chained mode uses bytes whose 16-bit combination is far from either 8-bit value, so a wrong byte order or a missing carry is caught. A reload rewritten just after a period starts must leave that period at its old widths and change only the next one. This shows whether the shadow copy is taken at the boundary.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
   localparam int NCH         = 2;
   localparam int PINS_PER_CH = 2;
   localparam int SEL_W       = 3;
   localparam int CTRL_ADDR   = 4;
   localparam int FLAG_ADDR   = 5;

   typedef struct packed {
      logic [SEL_W-1:0] div_sel;
      logic             chain;
   } ctrl_t;
endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
   parameter int PRE_LOG = 4,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);
   logic [PRE_LOG-1:0] cnt_q;
   logic [PRE_LOG-1:0] mask;
   int                 shift;

   if (PRE_LOG < 1) begin : g_bad_log
      $error("PRE_LOG must be at least 1");
   end

   always_comb begin
      shift = (int'(div_sel) > PRE_LOG) ? PRE_LOG : int'(div_sel);
      for (int i = 0; i < PRE_LOG; i++) mask[i] = (i < shift);
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = ((cnt_q & mask) == mask);
endmodule

// File: rtl/ppg_core.sv
module ppg_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] lo_val,
   input  logic [W-1:0] hi_val,
   output logic         hi_lvl,
   output logic         lo_lvl,
   output logic         per_end
);
   logic         active_q;
   logic         phase_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] hi_sh_q;
   logic         at_zero;

   if (W < 2) begin : g_bad_w
      $error("counter width must be at least 2");
   end

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         cnt_q    <= '0;
         hi_sh_q  <= '0;
      end else if (!run) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
      end else if (!active_q) begin
         active_q <= 1'b1;
         phase_q  <= 1'b0;
         cnt_q    <= lo_val;
         hi_sh_q  <= hi_val;
      end else if (tick) begin
         if (!at_zero) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (!phase_q) begin
            phase_q <= 1'b1;
            cnt_q   <= hi_sh_q;
         end else begin
            phase_q <= 1'b0;
            cnt_q   <= lo_val;
            hi_sh_q <= hi_val;
         end
      end
   end

   assign hi_lvl  = active_q & phase_q;
   assign lo_lvl  = active_q & ~phase_q;
   assign per_end = run & active_q & tick & at_zero & phase_q;
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
   import ppg_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter int PRE_LOG  = 4,
   parameter int ADDR_W   = 3,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [CH_W-1:0]             wr_data,
   input  logic [NCH-1:0]              run_en,
   input  logic [NCH*PINS_PER_CH-1:0]  out_en,
   output logic [NCH*PINS_PER_CH-1:0]  pulse_out,
   output logic [NCH-1:0]              irq
);
   localparam int NPIN = NCH * PINS_PER_CH;
   localparam int CW2  = 2 * CH_W;

   if (CH_W < SEL_W + 1) begin : g_bad_cw
      $error("data width too small for control byte");
   end
   if ((1 << ADDR_W) <= FLAG_ADDR) begin : g_bad_aw
      $error("address width too small for register map");
   end

   logic [CH_W-1:0] lo_q [NCH];
   logic [CH_W-1:0] hi_q [NCH];
   ctrl_t           ctrl_q;
   logic [NCH-1:0]  flag_q;
   logic            tick;
   logic            chain_on;
   logic [NCH-1:0]  hi8, lo8, end8, pend;
   logic            hi16, lo16, end16;

   assign chain_on = CHAIN_EN && ctrl_q.chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NCH; k++) begin
            lo_q[k] <= '0;
            hi_q[k] <= '0;
         end
         ctrl_q <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < NCH; k++) begin
            if (int'(wr_addr) == 2 * k)     lo_q[k] <= wr_data;
            if (int'(wr_addr) == 2 * k + 1) hi_q[k] <= wr_data;
         end
         if (int'(wr_addr) == CTRL_ADDR) ctrl_q <= wr_data[SEL_W:0];
      end
   end

   ppg_prescaler #(.PRE_LOG(PRE_LOG), .SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst(rst), .div_sel(ctrl_q.div_sel), .tick(tick)
   );

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      ppg_core #(.W(CH_W)) u_core (
         .clk(clk), .rst(rst), .run(run_en[k] & ~chain_on), .tick(tick),
         .lo_val(lo_q[k]), .hi_val(hi_q[k]),
         .hi_lvl(hi8[k]), .lo_lvl(lo8[k]), .per_end(end8[k])
      );
      assign pulse_out[PINS_PER_CH*k]   = out_en[PINS_PER_CH*k]   & (chain_on ? hi16 : hi8[k]);
      assign pulse_out[PINS_PER_CH*k+1] = out_en[PINS_PER_CH*k+1] & (chain_on ? lo16 : lo8[k]);
      assign pend[k] = chain_on ? ((k == 0) ? end16 : 1'b0) : end8[k];
   end

   if (CHAIN_EN) begin : g_chain
      logic [CW2-1:0] lo_cat, hi_cat;
      assign lo_cat = {lo_q[1], lo_q[0]};
      assign hi_cat = {hi_q[1], hi_q[0]};
      ppg_core #(.W(CW2)) u_core16 (
         .clk(clk), .rst(rst), .run(run_en[0] & chain_on), .tick(tick),
         .lo_val(lo_cat), .hi_val(hi_cat),
         .hi_lvl(hi16), .lo_lvl(lo16), .per_end(end16)
      );
   end else begin : g_nochain
      assign hi16  = 1'b0;
      assign lo16  = 1'b0;
      assign end16 = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= '0;
      end else begin
         for (int k = 0; k < NCH; k++) begin
            if (pend[k])
               flag_q[k] <= 1'b1;
            else if (wr_en && int'(wr_addr) == FLAG_ADDR && !wr_data[k])
               flag_q[k] <= 1'b0;
         end
      end
   end

   assign irq = flag_q;
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
   parameter int ADDR_W = 3,
   parameter int DW     = 8,
   parameter int NCH    = 2,
   parameter int NPIN   = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DW-1:0]     wr_data,
   input logic [NCH-1:0]    run_en,
   input logic [NPIN-1:0]   out_en,
   input logic [NPIN-1:0]   pulse_out,
   input logic [NCH-1:0]    irq
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   // R7
   pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (pulse_out & ~out_en) == '0);

   // R8
   compl_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(run_en[0]) && out_en[1:0] == 2'b11) |-> (pulse_out[0] != pulse_out[1]));

   // R10
   stop_ch0_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(run_en[0])) |-> (pulse_out[1:0] == 2'b00));

   // R10
   stop_ch1_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(run_en[0]) && !$past(run_en[1])) |-> (pulse_out[3:2] == 2'b00));

   for (genvar k = 0; k < NCH; k++) begin : g_flag
      // R9
      flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
         (past_ok && $fell(irq[k])) |-> $past(wr_en && int'(wr_addr) == 5 && !wr_data[k]));
   end
endmodule

bind ppg_timer ppg_timer_chk #(.ADDR_W(ADDR_W), .DW(CH_W)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .run_en(run_en), .out_en(out_en), .pulse_out(pulse_out), .irq(irq)
);

// File: tb/ppg_timer_tb.sv
module ppg_timer_tb_top;
   typedef struct { int lo_c; int hi_c; string req; } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] run_en = '0;
   logic [3:0] out_en = '0;
   logic [3:0] pulse_out;
   logic [1:0] irq;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];
   bit   mon_on = 1'b0;
   int   mon_pin = 0;
   int   mst = 0;
   int   lo_cnt = 0;
   int   hi_cnt = 0;
   bit   pv = 1'b0;

   always #2.5 clk = ~clk;

   ppg_timer dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .run_en(run_en), .out_en(out_en), .pulse_out(pulse_out), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = 8'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // monitor: measures low then high width of each period on mon_pin
   always @(negedge clk) begin
      bit v;
      exp_t e;
      v = pulse_out[mon_pin];
      if (!mon_on) begin
         mst = 0;
      end else begin
         case (mst)
            0: if (pv && !v) begin mst = 1; lo_cnt = 1; end
            1: if (!v) lo_cnt++; else begin mst = 2; hi_cnt = 1; end
            default: begin
               if (v) hi_cnt++;
               else begin
                  if (exp_q.size() > 0) begin
                     e = exp_q.pop_front();
                     n_chk++;
                     if (lo_cnt != e.lo_c || hi_cnt != e.hi_c) begin
                        n_fail++;
                        $display("FAIL %s: actual low/high %0d/%0d expected %0d/%0d",
                                 e.req, lo_cnt, hi_cnt, e.lo_c, e.hi_c);
                     end
                  end
                  mst = 1;
                  lo_cnt = 1;
               end
            end
         endcase
      end
      pv = v;
   end

   task automatic push(input int lo_c, input int hi_c, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.lo_c = lo_c; e.hi_c = hi_c; e.req = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic drain(input string req);
      int t = 0;
      while (exp_q.size() > 0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      if (exp_q.size() > 0) begin
         check(1'b0, req, exp_q.size(), 0);
         exp_q.delete();
      end
      mon_on = 1'b0;
   endtask

   task automatic setup(input int ctrl, input int l0, input int h0, input int l1, input int h1);
      run_en = 2'b00;
      mon_on = 1'b0;
      @(negedge clk);
      wr(0, l0); wr(1, h0); wr(2, l1); wr(3, h1); wr(4, ctrl);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(pulse_out == 4'b0000, "R1 pins", int'(pulse_out), 0);
      check(irq == 2'b00, "R1 flags", int'(irq), 0);

      // R2 basic waveform, divide by 1
      out_en = 4'hF;
      setup(0, 3, 1, 0, 0);
      run_en = 2'b01;
      mon_pin = 0; mon_on = 1'b1;
      push(4, 2, 2, "R2");
      drain("R2 timeout");

      // R8 complement pin
      begin
         bit ok = 1'b1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pulse_out[1] == pulse_out[0]) ok = 1'b0;
         end
         check(ok, "R8 complement", int'(pulse_out[1:0]), 1);
      end

      // R7 output enable gating
      begin
         bit ok = 1'b1;
         int tog = 0;
         bit last = pulse_out[1];
         out_en = 4'b1110;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pulse_out[0]) ok = 1'b0;
            if (pulse_out[1] != last) tog++;
            last = pulse_out[1];
         end
         check(ok && tog > 0, "R7 disabled pin low", tog, 1);
         out_en = 4'hF;
      end

      // R10 stop and restart
      @(negedge clk);
      run_en = 2'b00;
      @(negedge clk);
      check(pulse_out[1:0] == 2'b00, "R10 stop", int'(pulse_out[1:0]), 0);
      repeat (3) @(negedge clk);
      run_en = 2'b01;
      begin
         int n = 0;
         @(negedge clk);
         while (!pulse_out[0] && n < 100) begin
            n++;
            @(negedge clk);
         end
         check(n == 4, "R10 full low phase on restart", n, 4);
      end

      // R6 reload takes effect at the next period
      setup(0, 4, 2, 0, 0);
      run_en = 2'b01;
      mon_pin = 0; mon_on = 1'b1;
      push(5, 3, 1, "R6 old period");
      push(2, 1, 1, "R6 new period");
      wait (mst == 1);
      wr(0, 1); wr(1, 0);
      drain("R6 timeout");

      // R3 prescaler codes
      setup(2 << 1, 1, 2, 0, 0);
      run_en = 2'b01; mon_on = 1'b1;
      push(8, 12, 2, "R3 div4");
      drain("R3 timeout");
      setup(1 << 1, 2, 0, 0, 0);
      run_en = 2'b01; mon_on = 1'b1;
      push(6, 2, 2, "R3 div2");
      drain("R3 timeout");
      setup(6 << 1, 0, 0, 0, 0);
      run_en = 2'b01; mon_on = 1'b1;
      push(16, 16, 2, "R3 code6 div16");
      drain("R3 timeout");

      // R4 independent channel 1
      setup(0, 1, 1, 5, 2);
      run_en = 2'b11;
      mon_pin = 2; mon_on = 1'b1;
      push(6, 3, 2, "R4 channel1");
      drain("R4 timeout");

      // R5 chained 16-bit operation
      setup(1, 2, 5, 1, 0);
      run_en = 2'b01;
      mon_pin = 0; mon_on = 1'b1;
      push(259, 6, 2, "R5 chained");
      drain("R5 timeout");

      // R9 flags
      run_en = 2'b00;
      repeat (2) @(negedge clk);
      check(irq == 2'b11, "R9 flags set", int'(irq), 3);
      wr(5, 8'hFF);
      check(irq == 2'b11, "R9 write one keeps", int'(irq), 3);
      wr(5, 8'hFE);
      check(irq == 2'b10, "R9 clear flag0", int'(irq), 2);
      wr(5, 8'hFD);
      check(irq == 2'b00, "R9 clear flag1", int'(irq), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule